// File: doc/BRIEF.md
# Peripheral Clock Gating Controller

This block holds one enable bit for each of a set of peripherals and turns each bit into a registered clock-enable output. That output can drive a glitch-free clock gate or the clock-enable port of the peripheral. Software writes the enable bits through a small byte-wide register bus. With the default parameters there are 32 peripherals, held as four 8-bit registers, one bit per peripheral. A low-power stop input forces every clock-enable output low. The stored bits are left untouched, so the previous state returns when stop ends.

The block also sits on the access path to the peripherals and filters accesses aimed at a peripheral that is switched off.

- For most peripherals, a gated access is quietly dropped. A write is not forwarded. A read returns zero.
- A parameter mask names a subset of peripherals that must not be accessed blind. For these, an access raises a one-cycle error flag if the clock is off or if the per-peripheral availability input is low.

Top module: `periph_clk_gate`

## Requirements
- R1: After reset every enable bit reads back as 1, so every register reads 0xFF. Every `clk_en` bit is 1.
- R2: A register write at address k (bit n of register k is peripheral 8*k+n) updates the stored bits and `clk_en[8k+7:8k]` at the same clock edge, when stop is low. There is no further delay stage.
- R3: A write strobe to a peripheral that is outside the error mask and whose enable bit is 0 is not forwarded (`fwd_wr` stays 0) and raises no error.
- R4: A read strobe to a peripheral that is outside the error mask and whose enable bit is 0 returns `acc_rdata` = 0, keeps `fwd_rd` at 0 and raises no error.
- R5: A read or write to a peripheral in the error mask whose enable bit is 0 drives `acc_err` high in the same cycle as the strobe. The access is not forwarded.
- R6: A peripheral in the error mask whose `avail` bit is 0 raises `acc_err` on access even when its enable bit is 1. For a peripheral outside the mask, `avail` is ignored.
- R7: One clock edge after `stop_mode` is sampled high, all `clk_en` bits are 0, whatever the enable bits hold. One edge after `stop_mode` is sampled low, they follow the stored bits again.
- R8: The registers can be read back at all times, including during stop. A write made during stop is stored.
- R9: An access to an enabled, available peripheral is forwarded. `fwd_wr`/`fwd_rd` follow the strobes, `acc_rdata` equals `pr_rdata`, and `acc_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_mode | input | 1 | Low-power stop request, forces all clock enables off |
| reg_wr | input | 1 | Enable-register write strobe |
| reg_addr | input | 2 | Enable-register index |
| reg_wdata | input | 8 | Enable-register write data |
| reg_rdata | output | 8 | Enable-register read data |
| acc_sel | input | NPER | One-hot peripheral select of the access path |
| acc_wr | input | 1 | Peripheral write strobe |
| acc_rd | input | 1 | Peripheral read strobe |
| avail | input | NPER | Per-peripheral availability |
| pr_rdata | input | 8 | Read data returned by the selected peripheral |
| fwd_wr | output | 1 | Forwarded write strobe |
| fwd_rd | output | 1 | Forwarded read strobe |
| acc_rdata | output | 8 | Read data returned to the bus master |
| acc_err | output | 1 | Access-error pulse |
| clk_en | output | NPER | Registered per-peripheral clock enables |

## Verification
The access filter is tried with a table of accesses that crosses three things: reads against writes, peripherals inside and outside the error mask, and enable and availability settings. This tells silent dropping apart from error signalling, and a forwarded access apart from a blocked one. It also shows that availability matters only inside the mask. Register writes are checked on the exact edge at which `clk_en` should change. A stop sequence with a write in the middle separates the forced-off outputs from the retained and still-writable stored bits.

// File: rtl/periph_clk_gate.sv
module periph_clk_gate #(
  parameter int NPER = 32,
  parameter int RW = 8,
  parameter logic [NPER-1:0] ERR_MASK = 32'h0000_0003,
  localparam int NREG = NPER / RW,
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stop_mode,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [RW-1:0]   reg_wdata,
  output logic [RW-1:0]   reg_rdata,
  input  logic [NPER-1:0] acc_sel,
  input  logic            acc_wr,
  input  logic            acc_rd,
  input  logic [NPER-1:0] avail,
  input  logic [RW-1:0]   pr_rdata,
  output logic            fwd_wr,
  output logic            fwd_rd,
  output logic [RW-1:0]   acc_rdata,
  output logic            acc_err,
  output logic [NPER-1:0] clk_en
);

  logic [NPER-1:0] en_q, en_d, blocked, faulty;
  logic strobe, open_acc;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign en_d[r*RW +: RW] = (reg_wr && reg_addr == AW'(r)) ? reg_wdata : en_q[r*RW +: RW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '1;
      clk_en <= '1;
    end else begin
      en_q   <= en_d;
      clk_en <= stop_mode ? '0 : en_d;
    end
  end

  assign reg_rdata = en_q[reg_addr*RW +: RW];

  assign faulty   = ERR_MASK & (~en_q | ~avail);
  assign blocked  = ~en_q | faulty;
  assign strobe   = acc_wr | acc_rd;
  assign open_acc = |(acc_sel & ~blocked);

  assign fwd_wr    = acc_wr & open_acc;
  assign fwd_rd    = acc_rd & open_acc;
  assign acc_rdata = fwd_rd ? pr_rdata : '0;
  assign acc_err   = strobe & |(acc_sel & faulty);

endmodule

// File: rtl/periph_clk_gate_chk.sv
module periph_clk_gate_chk #(
  parameter int NPER = 32,
  parameter int RW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stop_mode,
  input logic            acc_wr,
  input logic            acc_rd,
  input logic            fwd_wr,
  input logic            fwd_rd,
  input logic            acc_err,
  input logic [RW-1:0]   acc_rdata,
  input logic [NPER-1:0] clk_en,
  input logic [NPER-1:0] en_q
);

  AST_STOP_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_mode) |-> clk_en == '0); // R7

  AST_CLKEN_TRACKS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stop_mode) |-> clk_en == en_q); // R2

  AST_ERR_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> !fwd_wr && !fwd_rd); // R5

  AST_ERR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (acc_wr || acc_rd)); // R5

  AST_DROPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !fwd_rd) |-> acc_rdata == '0); // R4

  AST_FWD_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_wr |-> acc_wr) and (fwd_rd |-> acc_rd)); // R9

endmodule

bind periph_clk_gate periph_clk_gate_chk #(.NPER(NPER), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .acc_wr(acc_wr), .acc_rd(acc_rd),
  .fwd_wr(fwd_wr), .fwd_rd(fwd_rd), .acc_err(acc_err), .acc_rdata(acc_rdata),
  .clk_en(clk_en), .en_q(en_q)
);

// File: tb/sim_periph_clk_gate.sv
module sim_periph_clk_gate;
  localparam int TCLK = 10;
  localparam int NPER = 32;
  localparam logic [7:0] PRD = 8'hA5;

  logic clk = 0, rst_n = 0, stop_mode = 0, reg_wr = 0, acc_wr = 0, acc_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, acc_rdata;
  logic [NPER-1:0] acc_sel = 0, avail = '1, clk_en;
  logic fwd_wr, fwd_rd, acc_err;
  int checks = 0, errors = 0;
  bit done = 0;

  periph_clk_gate u0 (
    .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_sel(acc_sel), .acc_wr(acc_wr), .acc_rd(acc_rd), .avail(avail),
    .pr_rdata(PRD), .fwd_wr(fwd_wr), .fwd_rd(fwd_rd), .acc_rdata(acc_rdata),
    .acc_err(acc_err), .clk_en(clk_en)
  );

  always #(TCLK/2) clk = ~clk;

  // {idx[4:0], wr, rd, make_unavailable, exp_fwd, exp_err, exp_pass}
  localparam int NV = 10;
  localparam logic [10:0] VEC [NV] = '{
    {5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {5'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {5'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {5'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {5'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rreg(input string req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk); reg_addr = a; #1;
    check(req, {24'h0, reg_rdata}, {24'h0, exp});
  endtask

  initial begin
    #(TCLK * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(TCLK * 2); rst_n = 1;
    check("R1 clk_en", clk_en, 32'hFFFF_FFFF);
    for (int a = 0; a < 4; a++) rreg("R1 readback", 2'(a), 8'hFF);

    // R2: same-edge update
    @(negedge clk); reg_wr = 1; reg_addr = 2'd2; reg_wdata = 8'h0F;
    #1; check("R2 before edge", clk_en, 32'hFFFF_FFFF);
    @(posedge clk); #1;
    check("R2 after edge", clk_en, 32'hFF0F_FFFF);
    @(negedge clk); reg_wr = 0;
    rreg("R2 readback", 2'd2, 8'h0F);

    // access table: p0 off (error set), p1 on (error set), p2/p3 off, p4+ on
    wreg(2'd0, 8'hF2);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      acc_sel = '0; acc_sel[VEC[i][10:6]] = 1'b1;
      acc_wr = VEC[i][5]; acc_rd = VEC[i][4];
      avail = '1; if (VEC[i][3]) avail[VEC[i][10:6]] = 1'b0;
      #1;
      // R3 R4 R5 R6 R9
      check($sformatf("R3/R9 fwd_wr vec%0d", i), {31'h0, fwd_wr}, {31'h0, VEC[i][2] & VEC[i][5]});
      check($sformatf("R4/R9 fwd_rd vec%0d", i), {31'h0, fwd_rd}, {31'h0, VEC[i][2] & VEC[i][4]});
      check($sformatf("R5/R6 err vec%0d", i), {31'h0, acc_err}, {31'h0, VEC[i][1]});
      if (VEC[i][4])
        check($sformatf("R4/R9 rdata vec%0d", i), {24'h0, acc_rdata}, VEC[i][0] ? {24'h0, PRD} : 32'h0);
    end
    @(negedge clk); acc_wr = 0; acc_rd = 0; avail = '1; #1;
    check("R5 no strobe no error", {31'h0, acc_err}, 32'h0);

    // R7 / R8: stop
    @(negedge clk); stop_mode = 1;
    @(posedge clk); #1;
    check("R7 stop off", clk_en, 32'h0);
    rreg("R8 readback in stop", 2'd2, 8'h0F);
    wreg(2'd3, 8'h55);
    check("R7 still off", clk_en, 32'h0);
    rreg("R8 write in stop", 2'd3, 8'h55);
    @(negedge clk); stop_mode = 0;
    @(posedge clk); #1;
    check("R7 resume", clk_en, 32'h550F_FFF2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule